// File: doc/BRIEF.md
# Streaming Packet Checker

The checker is the sink at the end of a 64-bit streaming receive path. It reads from an upstream buffer by driving a read enable, and takes a beat only when the buffer presents valid data while that enable is high. A test input can pull the enable low to create backpressure.

For each packet it checks three things:
- the start/end framing;
- the header's marker and serial number;
- the payload against a known pattern.

It keeps saturating counters of packets, payload words, serial-number errors, header errors and payload errors. It also counts data-path parity events, which are reported by a level flag and counted on each change of that flag. A one-cycle, three-bit pulse reports each framing violation and names which of the three rules was broken. Reset clears every counter and all sequence state.

A packet begins with a header beat marked by start-of-packet. Zero or more payload beats follow, and the beat carrying end-of-packet closes the packet. A single beat may carry both marks, which makes a header-only packet.

Top module: `stream_pkt_checker`

## Requirements
- R1: `rx_ena` is low during reset. Afterwards, at each clock edge it takes the inverse of `throttle`, so it reflects `throttle` one cycle late.
- R2: A beat is accepted only in a cycle where both `rx_valid` and `rx_ena` are high. A beat that is not accepted changes no counter and no state.
- R3: An accepted end-of-packet beat without start-of-packet, arriving before any packet has been opened since reset, sets `proto_err` to 3'b001 for the next cycle. The beat is otherwise ignored.
- R4: An accepted end-of-packet beat without start-of-packet, arriving after a packet has already closed, sets `proto_err` to 3'b010 for the next cycle. The beat is otherwise ignored.
- R5: An accepted start-of-packet beat that arrives while a packet is open sets `proto_err` to 3'b100 for the next cycle. The old packet is abandoned without being counted, and the beat starts a new packet.
- R6: A header beat carries:
  - a marker in bits [63:48], which must equal 16'hA55A;
  - the serial number in bits [47:32];
  - the payload length in beats in bits [31:16].
  A wrong marker adds one to `cnt_hdr_err`, and the serial number of that header is not checked.
- R7: The first header with a good marker loads the expected serial number as its serial plus one, and reports no error. After that, each header with a good marker whose serial differs from the expected value adds one to `cnt_sn_err`. Every header with a good marker sets the expected value to its own serial plus one.
- R8: Payload beat k of a packet (k counted from 0) must equal {k, ~k}, each half 32 bits. A payload beat adds at most one to `cnt_pay_err`, and does so if either of these holds:
  - the beat does not match the pattern;
  - it is the end-of-packet beat and the number of payload beats differs from the header length.
  A header-only packet whose length is not 0 also adds one.
- R9: `cnt_pkt` adds one for each end-of-packet beat that closes an open packet. `cnt_words` adds one for each accepted payload beat, meaning a beat without start-of-packet inside an open packet.
- R10: `cnt_par_err` adds one each time `rx_parity_err` changes value, whether or not any beat is accepted. Holding the flag at one level adds nothing.
- R11: Every counter is `CNT_W` bits wide, holds at all-ones instead of wrapping, and returns to zero on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| throttle | input | 1 | Pulls the read enable low for backpressure |
| rx_ena | output | 1 | Read enable toward the upstream buffer |
| rx_valid | input | 1 | Upstream data valid |
| rx_sop | input | 1 | Start-of-packet mark |
| rx_eop | input | 1 | End-of-packet mark |
| rx_data | input | 64 | Beat data |
| rx_parity_err | input | 1 | Data-path parity error level flag |
| proto_err | output | 3 | Framing violation pulse: bit0 end-of-packet before any packet, bit1 repeated end-of-packet, bit2 repeated start-of-packet |
| cnt_pkt | output | CNT_W | Packets closed |
| cnt_words | output | CNT_W | Payload beats accepted |
| cnt_sn_err | output | CNT_W | Serial-number errors |
| cnt_hdr_err | output | CNT_W | Header marker errors |
| cnt_pay_err | output | CNT_W | Payload errors |
| cnt_par_err | output | CNT_W | Parity flag changes |

## Verification
The bench tells the two end-of-packet violations apart by sending one right after reset and another after a packet has closed. A design that kept a single open flag would report the same code for both.

It sends a start-of-packet in the middle of a packet and then checks two things: the abandoned packet is not counted, and the serial of the restarting header is still checked in sequence. It sends a header with a bad marker and then the serial that was expected, which catches a design that resyncs on a header it should have rejected. It also sends a packet one payload beat short of its length.

Valid beats presented while the enable is low must leave every counter unchanged. A parity flag held high for several cycles must count once, not once per cycle. A three-bit copy of the block, fed the same traffic, must stop at seven packets rather than wrap.

// File: rtl/stream_pkt_checker.sv
`timescale 1ns/1ps
module stream_pkt_checker #(
  parameter int CNT_W = 32,
  parameter logic [15:0] HDR_MARK = 16'hA55A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             throttle,
  output logic             rx_ena,
  input  logic             rx_valid,
  input  logic             rx_sop,
  input  logic             rx_eop,
  input  logic [63:0]      rx_data,
  input  logic             rx_parity_err,
  output logic [2:0]       proto_err,
  output logic [CNT_W-1:0] cnt_pkt,
  output logic [CNT_W-1:0] cnt_words,
  output logic [CNT_W-1:0] cnt_sn_err,
  output logic [CNT_W-1:0] cnt_hdr_err,
  output logic [CNT_W-1:0] cnt_pay_err,
  output logic [CNT_W-1:0] cnt_par_err
);

  typedef enum logic [1:0] {ST_FRESH, ST_OPEN, ST_CLOSED} frame_t;

  frame_t      state;
  logic        sn_live;
  logic [15:0] sn_next;
  logic [15:0] idx;
  logic [15:0] len_q;
  logic        par_q;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v, input logic en);
    return (en && (v != '1)) ? v + 1'b1 : v;
  endfunction

  wire        take    = rx_valid & rx_ena;
  wire        hdr_in  = take & rx_sop;
  wire        pay_in  = take & ~rx_sop & (state == ST_OPEN);
  wire        stray   = take & ~rx_sop & (state != ST_OPEN) & rx_eop;

  wire [15:0] h_mark  = rx_data[63:48];
  wire [15:0] h_sn    = rx_data[47:32];
  wire [15:0] h_len   = rx_data[31:16];
  wire        mark_ok = (h_mark == HDR_MARK);
  wire        sn_bad  = hdr_in & mark_ok & sn_live & (h_sn != sn_next);

  wire [31:0] idx_w   = {16'd0, idx};
  wire        pat_bad = (rx_data != {idx_w, ~idx_w});
  wire        len_bad = rx_eop & ((idx + 16'd1) != len_q);
  wire        pay_bad = (pay_in & (pat_bad | len_bad)) |
                        (hdr_in & rx_eop & (h_len != 16'd0));
  wire        closes  = (hdr_in & rx_eop) | (pay_in & rx_eop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_ena <= 1'b0;
    else        rx_ena <= ~throttle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_FRESH;
      proto_err <= 3'b000;
      idx       <= '0;
      len_q     <= '0;
    end else begin
      proto_err <= {hdr_in & (state == ST_OPEN),
                    stray & (state == ST_CLOSED),
                    stray & (state == ST_FRESH)};
      if (hdr_in) begin
        idx   <= '0;
        len_q <= h_len;
        state <= rx_eop ? ST_CLOSED : ST_OPEN;
      end else if (pay_in) begin
        idx <= idx + 16'd1;
        if (rx_eop) state <= ST_CLOSED;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sn_live <= 1'b0;
      sn_next <= '0;
    end else if (hdr_in && mark_ok) begin
      sn_live <= 1'b1;
      sn_next <= h_sn + 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q       <= 1'b0;
      cnt_pkt     <= '0;
      cnt_words   <= '0;
      cnt_sn_err  <= '0;
      cnt_hdr_err <= '0;
      cnt_pay_err <= '0;
      cnt_par_err <= '0;
    end else begin
      par_q       <= rx_parity_err;
      cnt_pkt     <= bump(cnt_pkt, closes);
      cnt_words   <= bump(cnt_words, pay_in);
      cnt_sn_err  <= bump(cnt_sn_err, sn_bad);
      cnt_hdr_err <= bump(cnt_hdr_err, hdr_in & ~mark_ok);
      cnt_pay_err <= bump(cnt_pay_err, pay_bad);
      cnt_par_err <= bump(cnt_par_err, rx_parity_err ^ par_q);
    end
  end

  p_ena_follows_throttle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ena |-> !$past(throttle));
  p_words_need_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_words) |-> $past(rx_valid && rx_ena));
  p_idle_eop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err[0] |-> $past(rx_valid && rx_ena && rx_eop && !rx_sop));
  p_dup_eop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err[1] |-> $past(rx_valid && rx_ena && rx_eop && !rx_sop));
  p_dup_sop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err[2] |-> $past(rx_valid && rx_ena && rx_sop));
  p_one_violation_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(proto_err));
  p_sn_err_on_header_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_sn_err) |-> $past(rx_valid && rx_ena && rx_sop));
  p_parity_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_par_err) |-> ($past(rx_parity_err) != $past(rx_parity_err, 2)));
  p_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pkt == '1) |=> (cnt_pkt == '1));

endmodule

// File: tb/tb_stream_pkt_checker.sv
`timescale 1ns/1ps
module tb_stream_pkt_checker;
  logic clk = 0, rst_n = 0, throttle = 1;
  logic rx_valid = 0, rx_sop = 0, rx_eop = 0, rx_parity_err = 0;
  logic [63:0] rx_data = '0;
  logic rx_ena, s_ena;
  logic [2:0] proto_err, s_proto;
  logic [31:0] c_pkt, c_words, c_sn, c_hdr, c_pay, c_par;
  logic [2:0] s_pkt, s_words, s_sn, s_hdr, s_pay, s_par;
  int n_chk = 0, n_fail = 0;
  int e_pkt = 0, e_words = 0, e_sn = 0, e_hdr = 0, e_pay = 0, e_par = 0;

  always #2 clk = ~clk;

  stream_pkt_checker dut (.clk, .rst_n, .throttle, .rx_ena, .rx_valid, .rx_sop, .rx_eop,
    .rx_data, .rx_parity_err, .proto_err, .cnt_pkt(c_pkt), .cnt_words(c_words),
    .cnt_sn_err(c_sn), .cnt_hdr_err(c_hdr), .cnt_pay_err(c_pay), .cnt_par_err(c_par));

  stream_pkt_checker #(.CNT_W(3)) dut_sat (.clk, .rst_n, .throttle, .rx_ena(s_ena), .rx_valid,
    .rx_sop, .rx_eop, .rx_data, .rx_parity_err, .proto_err(s_proto), .cnt_pkt(s_pkt),
    .cnt_words(s_words), .cnt_sn_err(s_sn), .cnt_hdr_err(s_hdr), .cnt_pay_err(s_pay),
    .cnt_par_err(s_par));

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_counts(input string req);
    chk({req, " pkt"}, c_pkt, e_pkt);
    chk({req, " words"}, c_words, e_words);
    chk({req, " sn_err"}, c_sn, e_sn);
    chk({req, " hdr_err"}, c_hdr, e_hdr);
    chk({req, " pay_err"}, c_pay, e_pay);
    chk({req, " par_err"}, c_par, e_par);
  endtask

  function automatic logic [63:0] hdr(input logic [15:0] mark, input logic [15:0] sn,
                                      input logic [15:0] len);
    return {mark, sn, len, 16'h0};
  endfunction

  function automatic logic [63:0] pw(input int k);
    return {32'(k), ~32'(k)};
  endfunction

  task automatic beat(input logic sop, input logic eop, input logic [63:0] d);
    rx_valid = 1; rx_sop = sop; rx_eop = eop; rx_data = d;
    @(negedge clk);
    rx_valid = 0; rx_sop = 0; rx_eop = 0;
  endtask

  task automatic packet(input logic [15:0] sn, input int len);
    beat(1, len == 0, hdr(16'hA55A, sn, 16'(len)));
    for (int k = 0; k < len; k++) beat(0, k == len - 1, pw(k));
    e_pkt++; e_words += len;
  endtask

  task automatic t_reset;
    chk("R1 ena in reset", rx_ena, 0);
    chk_counts("R11 reset");
    rst_n = 1; throttle = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 ena after throttle low", rx_ena, 1);
  endtask

  task automatic t_idle_eop;
    beat(0, 1, pw(0));
    chk("R3 eop before any packet", proto_err, 3'b001);
    @(negedge clk);
    chk("R3 pulse clears", proto_err, 3'b000);
    chk_counts("R3 stray ignored");
  endtask

  task automatic t_good;
    packet(16'd5, 3); packet(16'd6, 0); packet(16'd7, 2);
    chk_counts("R9 good packets");
  endtask

  task automatic t_dup_eop;
    beat(0, 1, pw(0));
    chk("R4 repeated eop", proto_err, 3'b010);
    chk_counts("R4 stray ignored");
  endtask

  task automatic t_serial;
    packet(16'd10, 1); e_sn++;
    chk_counts("R7 serial gap");
    packet(16'd11, 1);
    chk_counts("R7 resync");
  endtask

  task automatic t_header;
    beat(1, 0, hdr(16'h1234, 16'd99, 16'd1)); beat(0, 1, pw(0));
    e_pkt++; e_words++; e_hdr++;
    chk_counts("R6 bad marker");
    packet(16'd12, 1);
    chk_counts("R6 bad header skips serial");
  endtask

  task automatic t_payload;
    beat(1, 0, hdr(16'hA55A, 16'd13, 16'd3));
    beat(0, 0, pw(0)); beat(0, 0, pw(1) ^ 64'h10); beat(0, 1, pw(2));
    e_pkt++; e_words += 3; e_pay++;
    chk_counts("R8 corrupt word");
    beat(1, 0, hdr(16'hA55A, 16'd14, 16'd3));
    beat(0, 0, pw(0)); beat(0, 1, pw(1));
    e_pkt++; e_words += 2; e_pay++;
    chk_counts("R8 short packet");
    beat(1, 1, hdr(16'hA55A, 16'd15, 16'd2));
    e_pkt++; e_pay++;
    chk_counts("R8 header-only nonzero length");
  endtask

  task automatic t_dup_sop;
    beat(1, 0, hdr(16'hA55A, 16'd16, 16'd2)); beat(0, 0, pw(0));
    e_words++;
    beat(1, 0, hdr(16'hA55A, 16'd17, 16'd1));
    chk("R5 repeated sop", proto_err, 3'b100);
    beat(0, 1, pw(0));
    e_pkt++; e_words++;
    chk_counts("R5 restart packet");
  endtask

  task automatic t_backpressure;
    throttle = 1;
    @(negedge clk);
    chk("R1 ena drops", rx_ena, 0);
    beat(1, 0, hdr(16'hA55A, 16'd50, 16'd1)); beat(0, 1, pw(0)); beat(0, 1, pw(0));
    chk("R2 no proto while blocked", proto_err, 0);
    chk_counts("R2 blocked beats ignored");
    throttle = 0;
    @(negedge clk);
    packet(16'd18, 1);
    chk_counts("R2 resumes");
  endtask

  task automatic t_parity;
    rx_parity_err = 1; repeat (5) @(negedge clk);
    e_par++;
    chk_counts("R10 level held");
    rx_parity_err = 0; @(negedge clk); @(negedge clk);
    e_par++;
    chk_counts("R10 second change");
  endtask

  task automatic t_saturate;
    chk("R11 narrow pkt holds", s_pkt, 7);
    chk("R11 narrow words holds", s_words, 7);
    chk("R11 narrow par", s_par, 2);
    rst_n = 0; @(negedge clk);
    e_pkt = 0; e_words = 0; e_sn = 0; e_hdr = 0; e_pay = 0; e_par = 0;
    chk_counts("R11 reset clears");
    chk("R11 narrow reset", s_pkt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_idle_eop;
    t_good;
    t_dup_eop;
    t_serial;
    t_header;
    t_payload;
    t_dup_sop;
    t_backpressure;
    t_parity;
    t_saturate;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule